// File: doc/BRIEF.md
# Next-Fetch-Address and Control-Transfer Unit

This block keeps the fetch pointer and the instruction register of a single-cycle processor core. Every cycle it presents the fetch pointer to instruction memory, and at the clock edge it captures the returned word into the instruction register while the pointer advances. The word held in the instruction register is decoded for control transfers. A 26-bit absolute jump replaces the low 28 address bits. A register jump loads a full 32-bit value from the register file. Two conditional branches add a signed word offset relative to the advanced pointer. Every other opcode falls through to sequential fetch.

The unit drives the two register-file read indices straight from the instruction register and gets the two operands back in the same cycle. Branch decisions come from a compare that subtracts the second operand from the first and discards the difference. The N, V, C and Z results of that compare are exported together with a redirect strobe. The fetch pointer runs one word ahead of the instruction being decoded, so it already equals the decoded instruction's address plus 4. When a transfer is taken, the word fetched in that cycle is dropped and the instruction register loads a no-op. No instruction after a transfer is executed early.

Top module: `npc_unit`

## Requirements
- R1: A synchronous active-high `rst` sampled at a clock edge sets `fetch_addr` to 0x00000000 and `ir_word` to the no-op value 0x00000000.
- R2: When no transfer is taken, at the edge `fetch_addr` becomes `fetch_addr + 4`, wrapping modulo 2^32, and `ir_word` captures `fetch_word`. Opcodes other than the four transfer opcodes in R3, R4 and R6 never redirect.
- R3: Opcode 6'b000010 in `ir_word[31:26]` is an absolute jump. At the edge, bits 27:0 of `fetch_addr` become `{ir_word[25:0], 2'b00}` and bits 31:28 keep their value. For example, word 0x08100010 with a zero upper nibble gives 0x00400040.
- R4: Opcode 6'b000011 is a register jump. `rs_idx_a` equals `ir_word[25:21]`, and at the edge `fetch_addr` loads `rs_val_a` unshifted.
- R5: For the branch opcodes, `rs_idx_a` equals `ir_word[25:21]` and `rs_idx_b` equals `ir_word[20:16]`. The signed word offset is `ir_word[15:0]`.
- R6: Opcode 6'b000100 is taken when Z=1. Its target is `fetch_addr + (sign-extended offset << 2)`, where `fetch_addr` already equals the branch address plus 4. For example, word 0x10220CFF fetched at 0x00001000 with equal operands gives 0x00004400.
- R7: Opcode 6'b000101 is taken when Z=0 and uses the same target as R6. A branch that is not taken follows R2.
- R8: The flags describe `rs_val_a - rs_val_b`. N is bit 31 of the difference. Z is 1 when the difference is zero. C is 1 when there is no borrow, that is when `rs_val_a >= rs_val_b` unsigned. V is 1 on signed overflow of the subtraction.
- R9: `redirect` is high exactly when a transfer is taken. After such an edge, `ir_word` holds 0x00000000 instead of the fetched word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_addr | output | 32 | Instruction-memory byte address (fetch pointer) |
| fetch_word | input | 32 | Word returned from instruction memory for `fetch_addr` |
| ir_word | output | 32 | Instruction register contents (instruction being decoded) |
| rs_idx_a | output | 5 | First register-file read index |
| rs_idx_b | output | 5 | Second register-file read index |
| rs_val_a | input | 32 | Value read at `rs_idx_a` |
| rs_val_b | input | 32 | Value read at `rs_idx_b` |
| flag_n | output | 1 | Compare result negative |
| flag_v | output | 1 | Compare signed overflow |
| flag_c | output | 1 | Compare carry (no borrow) |
| flag_z | output | 1 | Compare result zero |
| redirect | output | 1 | Transfer taken this cycle |

## Verification
The properties assume that reset is asserted at the first clock edge, and that `fetch_word` and both operand inputs settle before each rising edge and stay stable through it. They treat the operands as whatever the register file returns for the exported indices, so they do not assume that the indices and the values match. The stimulus drives every input at the falling edge and raises reset before the first rising edge. Before each vector it uses a register jump to place the fetch pointer, so each vector starts from a non-transfer instruction register and a known pointer.

// File: rtl/npc_pkg.sv
package npc_pkg;
    localparam int XLEN   = 32;
    localparam int OPC_W  = 6;
    localparam int RIDX_W = 5;
    localparam int OFF_W  = 16;
    localparam int JIDX_W = 26;
    localparam int STEP   = 4;

    localparam logic [OPC_W-1:0] OPC_JABS = 6'b000010;
    localparam logic [OPC_W-1:0] OPC_JREG = 6'b000011;
    localparam logic [OPC_W-1:0] OPC_BEQ  = 6'b000100;
    localparam logic [OPC_W-1:0] OPC_BNE  = 6'b000101;

    localparam logic [XLEN-1:0] IR_NOP   = '0;
    localparam logic [XLEN-1:0] PC_RESET = '0;

    typedef enum logic [2:0] {
        FLOW_SEQ,
        FLOW_JABS,
        FLOW_JREG,
        FLOW_BEQ,
        FLOW_BNE
    } flow_e;

    typedef struct packed {
        flow_e              kind;
        logic [RIDX_W-1:0]  ra;
        logic [RIDX_W-1:0]  rb;
        logic [OFF_W-1:0]   off;
        logic [JIDX_W-1:0]  jidx;
    } dec_t;

    typedef struct packed {
        logic n;
        logic v;
        logic c;
        logic z;
    } flags_t;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] ir;
    } fetch_state_t;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] ir,
    output dec_t         dec
);
    localparam int OPC_LSB = W - OPC_W;
    localparam int RA_LSB  = OPC_LSB - RIDX_W;
    localparam int RB_LSB  = RA_LSB - RIDX_W;

    logic [OPC_W-1:0] opc;

    always_comb begin
        opc      = ir[W-1 -: OPC_W];
        dec.ra   = ir[RA_LSB +: RIDX_W];
        dec.rb   = ir[RB_LSB +: RIDX_W];
        dec.off  = ir[OFF_W-1:0];
        dec.jidx = ir[JIDX_W-1:0];
        unique case (opc)
            OPC_JABS: dec.kind = FLOW_JABS;
            OPC_JREG: dec.kind = FLOW_JREG;
            OPC_BEQ:  dec.kind = FLOW_BEQ;
            OPC_BNE:  dec.kind = FLOW_BNE;
            default:  dec.kind = FLOW_SEQ;
        endcase
    end
endmodule

// File: rtl/npc_compare.sv
module npc_compare
    import npc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output flags_t       flags
);
    logic [W:0]   sum;
    logic [W-1:0] diff;

    always_comb begin
        sum     = {1'b0, op_a} + {1'b0, ~op_b} + {{W{1'b0}}, 1'b1};
        diff    = sum[W-1:0];
        flags.c = sum[W];
        flags.n = diff[W-1];
        flags.z = (diff == '0);
        flags.v = (op_a[W-1] ^ op_b[W-1]) & (diff[W-1] ^ op_a[W-1]);
    end
endmodule

// File: rtl/npc_target.sv
module npc_target
    import npc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0]      pc_q,
    input  flow_e             kind,
    input  logic [OFF_W-1:0]  off,
    input  logic [JIDX_W-1:0] jidx,
    input  logic [W-1:0]      rs_a,
    input  logic              zero,
    output logic [W-1:0]      tgt,
    output logic              take
);
    localparam int SEXT_W = W - OFF_W - 2;
    localparam int KEEP_W = W - JIDX_W - 2;

    logic [W-1:0] rel_tgt;
    logic [W-1:0] abs_tgt;

    assign rel_tgt = pc_q + {{SEXT_W{off[OFF_W-1]}}, off, 2'b00};

    generate
        if (KEEP_W > 0) begin : g_keep_upper
            assign abs_tgt = {pc_q[W-1 -: KEEP_W], jidx, 2'b00};
        end else begin : g_full_field
            assign abs_tgt = {jidx[W-3:0], 2'b00};
        end
    endgenerate

    always_comb begin
        tgt  = rel_tgt;
        take = 1'b0;
        unique case (kind)
            FLOW_JABS: begin tgt = abs_tgt; take = 1'b1;  end
            FLOW_JREG: begin tgt = rs_a;    take = 1'b1;  end
            FLOW_BEQ:  begin tgt = rel_tgt; take = zero;  end
            FLOW_BNE:  begin tgt = rel_tgt; take = ~zero; end
            default:   begin tgt = rel_tgt; take = 1'b0;  end
        endcase
    end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    output logic [XLEN-1:0]     fetch_addr,
    input  logic [XLEN-1:0]     fetch_word,
    output logic [XLEN-1:0]     ir_word,
    output logic [RIDX_W-1:0]   rs_idx_a,
    output logic [RIDX_W-1:0]   rs_idx_b,
    input  logic [XLEN-1:0]     rs_val_a,
    input  logic [XLEN-1:0]     rs_val_b,
    output logic                flag_n,
    output logic                flag_v,
    output logic                flag_c,
    output logic                flag_z,
    output logic                redirect
);
    fetch_state_t    st_q;
    fetch_state_t    st_d;
    dec_t            dec;
    flags_t          flg;
    logic [XLEN-1:0] tgt;
    logic            take;

    npc_decode #(.W(XLEN)) u_dec (
        .ir  (st_q.ir),
        .dec (dec)
    );

    npc_compare #(.W(XLEN)) u_cmp (
        .op_a  (rs_val_a),
        .op_b  (rs_val_b),
        .flags (flg)
    );

    npc_target #(.W(XLEN)) u_tgt (
        .pc_q (st_q.pc),
        .kind (dec.kind),
        .off  (dec.off),
        .jidx (dec.jidx),
        .rs_a (rs_val_a),
        .zero (flg.z),
        .tgt  (tgt),
        .take (take)
    );

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.pc = PC_RESET;
            st_d.ir = IR_NOP;
        end else if (take) begin
            st_d.pc = tgt;
            st_d.ir = IR_NOP;
        end else begin
            st_d.pc = st_q.pc + XLEN'(STEP);
            st_d.ir = fetch_word;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign fetch_addr = st_q.pc;
    assign ir_word    = st_q.ir;
    assign rs_idx_a   = dec.ra;
    assign rs_idx_b   = dec.rb;
    assign flag_n     = flg.n;
    assign flag_v     = flg.v;
    assign flag_c     = flg.c;
    assign flag_z     = flg.z;
    assign redirect   = take;
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk
    import npc_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [XLEN-1:0]     fetch_addr,
    input logic [XLEN-1:0]     fetch_word,
    input logic [XLEN-1:0]     ir_word,
    input logic [RIDX_W-1:0]   rs_idx_a,
    input logic [RIDX_W-1:0]   rs_idx_b,
    input logic [XLEN-1:0]     rs_val_a,
    input logic [XLEN-1:0]     rs_val_b,
    input logic                flag_n,
    input logic                flag_v,
    input logic                flag_c,
    input logic                flag_z,
    input logic                redirect
);
    logic       past_rst_q;
    logic [5:0] opc;

    always_ff @(posedge clk) past_rst_q <= rst;
    assign opc = ir_word[31:26];

    // R1
    reset_state_chk: assert property (@(posedge clk)
        past_rst_q |-> (fetch_addr == '0 && ir_word == '0));

    // R2
    seq_step_chk: assert property (@(posedge clk) disable iff (rst)
        !redirect |=> (fetch_addr == $past(fetch_addr) + 32'd4 && ir_word == $past(fetch_word)));

    // R2
    other_opc_chk: assert property (@(posedge clk) disable iff (rst)
        (opc != OPC_JABS && opc != OPC_JREG && opc != OPC_BEQ && opc != OPC_BNE) |-> !redirect);

    // R3
    jump_abs_chk: assert property (@(posedge clk) disable iff (rst)
        (opc == OPC_JABS) |=> (fetch_addr[27:0] == {$past(ir_word[25:0]), 2'b00}
                               && fetch_addr[31:28] == $past(fetch_addr[31:28])));

    // R4
    jump_reg_chk: assert property (@(posedge clk) disable iff (rst)
        (opc == OPC_JREG) |=> (fetch_addr == $past(rs_val_a)));

    // R4
    jump_reg_idx_chk: assert property (@(posedge clk) disable iff (rst)
        (opc == OPC_JREG) |-> (rs_idx_a == ir_word[25:21]));

    // R5
    branch_idx_chk: assert property (@(posedge clk) disable iff (rst)
        (opc == OPC_BEQ || opc == OPC_BNE) |-> (rs_idx_a == ir_word[25:21] && rs_idx_b == ir_word[20:16]));

    // R6
    beq_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (opc == OPC_BEQ && flag_z) |=> (fetch_addr == $past(fetch_addr)
            + {{14{$past(ir_word[15])}}, $past(ir_word[15:0]), 2'b00}));

    // R7
    bne_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (opc == OPC_BNE && !flag_z) |=> (fetch_addr == $past(fetch_addr)
            + {{14{$past(ir_word[15])}}, $past(ir_word[15:0]), 2'b00}));

    // R8
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        flag_z == (rs_val_a == rs_val_b));

    // R8
    carry_flag_chk: assert property (@(posedge clk) disable iff (rst)
        flag_c == (rs_val_a >= rs_val_b));

    // R8
    sign_flag_chk: assert property (@(posedge clk) disable iff (rst)
        ($signed(rs_val_a) < $signed(rs_val_b)) == (flag_n ^ flag_v));

    // R9
    squash_chk: assert property (@(posedge clk) disable iff (rst)
        redirect |=> (ir_word == '0));
endmodule

bind npc_unit npc_unit_chk u_chk (.*);

// File: tb/tb_npc_unit.sv
`timescale 1ns/1ps
module tb_npc_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] fetch_addr;
    logic [31:0] fetch_word = 32'h0;
    logic [31:0] ir_word;
    logic [4:0]  rs_idx_a;
    logic [4:0]  rs_idx_b;
    logic [31:0] rs_val_a = 32'h0;
    logic [31:0] rs_val_b = 32'h0;
    logic        flag_n, flag_v, flag_c, flag_z, redirect;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    localparam logic [31:0] MARK  = 32'h2000_0001;
    localparam logic [31:0] JR_R1 = 32'h0C20_0000;

    typedef struct packed {
        logic [31:0] word;
        logic [31:0] fa;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] exp_pc;
        logic        exp_red;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{32'h10220CFF, 32'h00001000, 32'h5,        32'h5,        32'h00004400, 1'b1}, // R6 R10 example
        '{32'h10220CFF, 32'h00001000, 32'h5,        32'h6,        32'h00001008, 1'b0}, // R7 beq not taken
        '{32'h14220CFF, 32'h00001000, 32'h5,        32'h6,        32'h00004400, 1'b1}, // R7 bne taken
        '{32'h14220CFF, 32'h00001000, 32'h7,        32'h7,        32'h00001008, 1'b0}, // R7 bne not taken
        '{32'h1022FFFE, 32'h00002000, 32'h9,        32'h9,        32'h00001FFC, 1'b1}, // R6 negative offset
        '{32'h08100010, 32'h00001000, 32'h0,        32'h1,        32'h00400040, 1'b1}, // R3 example
        '{32'h0BFFFFFF, 32'hA0000100, 32'h1,        32'h0,        32'hAFFFFFFC, 1'b1}, // R3 nibble kept
        '{32'h0D000000, 32'h00000040, 32'h00400040, 32'h0,        32'h00400040, 1'b1}, // R4
        '{32'h0D400000, 32'h00000080, 32'h12345678, 32'h3,        32'h12345678, 1'b1}, // R4
        '{32'h20000000, 32'h00003000, 32'h4,        32'h4,        32'h00003008, 1'b0}, // R2 other opcode
        '{32'h00000000, 32'hFFFFFFF8, 32'h0,        32'h0,        32'h00000000, 1'b0}, // R2 wrap
        '{32'h10007FFF, 32'h00000000, 32'h3,        32'h3,        32'h00020000, 1'b1}, // R6 max offset
        '{32'h10008000, 32'h00100000, 32'h3,        32'h3,        32'h000E0004, 1'b1}, // R6 min offset
        '{32'h14220CFF, 32'h00001000, 32'h80000000, 32'h00000001, 32'h00004400, 1'b1}, // R8 overflow
        '{32'h1022FFFF, 32'h00000010, 32'h00000000, 32'h00000001, 32'h00000018, 1'b0}  // R8 borrow
    };

    npc_unit dut (
        .clk        (clk),
        .rst        (rst),
        .fetch_addr (fetch_addr),
        .fetch_word (fetch_word),
        .ir_word    (ir_word),
        .rs_idx_a   (rs_idx_a),
        .rs_idx_b   (rs_idx_b),
        .rs_val_a   (rs_val_a),
        .rs_val_b   (rs_val_b),
        .flag_n     (flag_n),
        .flag_v     (flag_v),
        .flag_c     (flag_c),
        .flag_z     (flag_z),
        .redirect   (redirect)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        logic [31:0] d;
        logic [5:0]  opc;
        logic        en, ev, ec, ez;
        opc = v.word[31:26];
        fetch_word = JR_R1;
        @(negedge clk);
        chk(rs_idx_a == 5'd1, "R4 index", {27'd0, rs_idx_a}, 32'd1);
        rs_val_a   = v.fa;
        fetch_word = MARK;
        @(negedge clk);
        chk(fetch_addr == v.fa && ir_word == 32'h0, "R4 load/R9 squash", fetch_addr, v.fa);
        fetch_word = v.word;
        @(negedge clk);
        chk(fetch_addr == v.fa + 32'd4 && ir_word == v.word, "R2 advance", fetch_addr, v.fa + 32'd4);
        rs_val_a   = v.a;
        rs_val_b   = v.b;
        fetch_word = MARK;
        #1;
        d  = v.a - v.b;
        en = d[31];
        ez = (v.a == v.b);
        ec = (v.a >= v.b);
        ev = (($signed(v.a) < $signed(v.b)) != d[31]);
        chk({flag_n, flag_v, flag_c, flag_z} == {en, ev, ec, ez}, "R8 flags",
            {28'd0, flag_n, flag_v, flag_c, flag_z}, {28'd0, en, ev, ec, ez});
        chk(redirect == v.exp_red, "R9 redirect", {31'd0, redirect}, {31'd0, v.exp_red});
        if (opc == 6'b000100 || opc == 6'b000101) begin
            chk(rs_idx_a == v.word[25:21] && rs_idx_b == v.word[20:16], "R5 indices",
                {22'd0, rs_idx_a, rs_idx_b}, {22'd0, v.word[25:21], v.word[20:16]});
        end
        @(negedge clk);
        if (opc == 6'b000010)      chk(fetch_addr == v.exp_pc, "R3 target", fetch_addr, v.exp_pc);
        else if (opc == 6'b000011) chk(fetch_addr == v.exp_pc, "R4 target", fetch_addr, v.exp_pc);
        else if (opc == 6'b000100) chk(fetch_addr == v.exp_pc, "R6 target", fetch_addr, v.exp_pc);
        else if (opc == 6'b000101) chk(fetch_addr == v.exp_pc, "R7 target", fetch_addr, v.exp_pc);
        else                       chk(fetch_addr == v.exp_pc, "R2 target", fetch_addr, v.exp_pc);
        chk(ir_word == (v.exp_red ? 32'h0 : MARK), "R9 ir after", ir_word, v.exp_red ? 32'h0 : MARK);
        if (idx == 0 || idx == 5)
            chk(fetch_addr == v.exp_pc, "R10 worked example", fetch_addr, v.exp_pc);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%08h expected=%08h", 32'h1, 32'h0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(fetch_addr == 32'h0, "R1 pc", fetch_addr, 32'h0);
        chk(ir_word == 32'h0, "R1 ir", ir_word, 32'h0);
        rst        = 1'b0;
        fetch_word = MARK;
        @(negedge clk);
        chk(fetch_addr == 32'h4 && ir_word == MARK, "R2 first step", fetch_addr, 32'h4);
        fetch_word = 32'h0;
        @(negedge clk);
        chk(fetch_addr == 32'h8, "R2 second step", fetch_addr, 32'h8);

        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i], i);
        end

        fetch_word = 32'h08100010;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(fetch_addr == 32'h0 && ir_word == 32'h0, "R1 mid-run reset", fetch_addr, 32'h0);
        rst        = 1'b0;
        fetch_word = 32'h0;
        @(negedge clk);
        chk(fetch_addr == 32'h4, "R2 after reset", fetch_addr, 32'h4);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule